// File: doc/BRIEF.md
# Bidirectional Shifting Q Register

This block is the auxiliary working register of one slice in a cascadable bit-slice datapath. On every rising clock edge it does one of four things: it takes the ALU result, it moves its contents one place toward the most significant end, it moves them one place toward the least significant end, or it keeps its value. A 3-bit destination code that the slice shares with its other destinations chooses the action.

Each end of the register has a bidirectional serial pin. When several slices are cascaded, these pins carry the bit that crosses from one slice into the next. During a shift the register drives the bit it loses out on the leading end and reads the bit it gains from the trailing end. For all codes that do not shift, it releases both pins.

Top module: `qsh_top`

## Requirements
- R1: While rst_ni is low, q_o is zero. The reset acts asynchronously, in the middle of a cycle, and it takes priority over a load or shift code at the next edge.
- R2: Destination code 3'b000 loads f_i into q_o on the next rising edge.
- R3: Destination code 3'b110 (shift up) makes the next q_o equal to {q_o[W-2:0], shift_lo_io}.
- R4: Destination code 3'b100 (shift down) makes the next q_o equal to {shift_hi_io, q_o[W-1:1]}.
- R5: While the code is 3'b110, shift_hi_io carries q_o[W-1] and shift_lo_io is released to high impedance.
- R6: While the code is 3'b100, shift_lo_io carries q_o[0] and shift_hi_io is released to high impedance.
- R7: Codes 3'b001, 3'b010, 3'b011, 3'b101 and 3'b111 leave q_o unchanged, whatever value f_i has.
- R8: For every code except 3'b100 and 3'b110, both shift pins are high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low clear |
| f_i | input | W | ALU result to load |
| dest_i | input | 3 | Destination code |
| shift_lo_io | inout | 1 | Serial pin at the bit-0 end |
| shift_hi_io | inout | 1 | Serial pin at the bit-(W-1) end |
| q_o | output | W | Register contents |

## Verification
The hardest case to create from the ports is a reset that arrives mid-cycle while a shift is in progress. At that moment one pin is driven by the register and the other by the bench. The bench drops rst_ni between clock edges while a shift-up code is applied and the neighbouring pin is held at 1. It then checks that q_o clears immediately, that it stays zero across the next edge, and that the high pin follows the cleared register. Long runs of random shifts in both directions check that the serial bits arrive in the right order. Between those runs, all eight codes are applied to confirm which pins are released.

// File: rtl/qsh_pkg.sv
package qsh_pkg;
  localparam logic [2:0] DST_LOAD = 3'b000;
  localparam logic [2:0] DST_DOWN = 3'b100;
  localparam logic [2:0] DST_UP   = 3'b110;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_UP   = 2'd2,
    OP_DOWN = 2'd3
  } qsh_op_e;
endpackage

// File: rtl/qsh_decode.sv
module qsh_decode
  import qsh_pkg::*;
(
  input  logic [2:0] dest_i,
  output qsh_op_e    op_o
);
  always_comb begin
    unique case (dest_i)
      DST_LOAD: op_o = OP_LOAD;
      DST_UP:   op_o = OP_UP;
      DST_DOWN: op_o = OP_DOWN;
      default:  op_o = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/qsh_reg.sv
module qsh_reg
  import qsh_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  qsh_op_e      op_i,
  input  logic [W-1:0] f_i,
  input  logic         lo_in_i,
  input  logic         hi_in_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    case (op_i)
      OP_LOAD: q_d = f_i;
      OP_UP:   q_d = {q_q[W-2:0], lo_in_i};
      OP_DOWN: q_d = {hi_in_i, q_q[W-1:1]};
      default: q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |=> q_o == '0);
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOAD |=> q_o == $past(f_i));
  a_r3_shift_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_UP |=> q_o == {$past(q_o[W-2:0]), $past(lo_in_i)});
  a_r4_shift_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_DOWN |=> q_o == {$past(hi_in_i), $past(q_o[W-1:1])});
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_HOLD |=> $stable(q_o));
endmodule

// File: rtl/qsh_pin_ctrl.sv
module qsh_pin_ctrl
  import qsh_pkg::*;
#(
  parameter int W = 4
) (
  input  qsh_op_e      op_i,
  input  logic [W-1:0] q_i,
  output logic         lo_oe_o,
  output logic         lo_val_o,
  output logic         hi_oe_o,
  output logic         hi_val_o
);
  // leading end drives the bit that falls out
  assign hi_oe_o  = (op_i == OP_UP);
  assign hi_val_o = q_i[W-1];
  assign lo_oe_o  = (op_i == OP_DOWN);
  assign lo_val_o = q_i[0];

  always_comb begin
    a_r8_one_end: assert ($onehot0({lo_oe_o, hi_oe_o}));
  end
endmodule

// File: rtl/qsh_top.sv
module qsh_top
  import qsh_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] f_i,
  input  logic [2:0]   dest_i,
  inout  wire          shift_lo_io,
  inout  wire          shift_hi_io,
  output logic [W-1:0] q_o
);
  qsh_op_e op;
  logic    lo_oe, lo_val, hi_oe, hi_val;

  qsh_decode u_dec (
    .dest_i (dest_i),
    .op_o   (op)
  );

  qsh_reg #(.W(W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .f_i     (f_i),
    .lo_in_i (shift_lo_io),
    .hi_in_i (shift_hi_io),
    .q_o     (q_o)
  );

  qsh_pin_ctrl #(.W(W)) u_pins (
    .op_i     (op),
    .q_i      (q_o),
    .lo_oe_o  (lo_oe),
    .lo_val_o (lo_val),
    .hi_oe_o  (hi_oe),
    .hi_val_o (hi_val)
  );

  assign shift_lo_io = lo_oe ? lo_val : 1'bz;
  assign shift_hi_io = hi_oe ? hi_val : 1'bz;

  a_r5_up_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_i == DST_UP |-> shift_hi_io == q_o[W-1]);
  a_r6_down_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_i == DST_DOWN |-> shift_lo_io == q_o[0]);
endmodule

// File: tb/qsh_top_test.sv
module qsh_top_test;
  localparam int W = 4;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [W-1:0] f_i;
  logic [2:0]   dest_i;
  logic [W-1:0] q_o;
  wire          shift_lo, shift_hi;
  logic         lo_en, lo_val, hi_en, hi_val;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q;

  assign shift_lo = lo_en ? lo_val : 1'bz;
  assign shift_hi = hi_en ? hi_val : 1'bz;

  always #(CLK_PERIOD/2) clk = ~clk;

  qsh_top #(.W(W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .f_i         (f_i),
    .dest_i      (dest_i),
    .shift_lo_io (shift_lo),
    .shift_hi_io (shift_hi),
    .q_o         (q_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one cycle: apply code, check pins, clock, check register
  task automatic step(input logic [2:0] code, input logic [W-1:0] f, input logic ser);
    @(negedge clk);
    dest_i = code; f_i = f;
    lo_en = 1'b0; hi_en = 1'b0;
    if (code == 3'b110) begin lo_en = 1'b1; lo_val = ser; end
    if (code == 3'b100) begin hi_en = 1'b1; hi_val = ser; end
    #1;
    if (code == 3'b110)
      chk("R5 hi pin", {{(W-1){1'b0}}, shift_hi}, {{(W-1){1'b0}}, exp_q[W-1]});
    else if (code == 3'b100)
      chk("R6 lo pin", {{(W-1){1'b0}}, shift_lo}, {{(W-1){1'b0}}, exp_q[0]});
    else begin
      chk("R8 lo pin z", {{(W-1){1'b0}}, shift_lo}, {{(W-1){1'b0}}, 1'bz});
      chk("R8 hi pin z", {{(W-1){1'b0}}, shift_hi}, {{(W-1){1'b0}}, 1'bz});
    end
    @(posedge clk);
    case (code)
      3'b000: exp_q = f;
      3'b110: exp_q = {exp_q[W-2:0], ser};
      3'b100: exp_q = {ser, exp_q[W-1:1]};
      default: ;
    endcase
    #1;
    case (code)
      3'b000: chk("R2 load", q_o, exp_q);
      3'b110: chk("R3 shift up", q_o, exp_q);
      3'b100: chk("R4 shift down", q_o, exp_q);
      default: chk("R7 hold", q_o, exp_q);
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; dest_i = 3'b000; f_i = 4'hF;
    lo_en = 1'b0; hi_en = 1'b0; lo_val = 1'b0; hi_val = 1'b0;
    exp_q = '0;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset state", q_o, '0);
    @(negedge clk) rst_ni = 1'b1;

    step(3'b000, 4'b1010, 1'b0);
    step(3'b110, 4'h0, 1'b1);
    step(3'b110, 4'h0, 1'b0);
    step(3'b100, 4'h0, 1'b1);
    step(3'b100, 4'h0, 1'b0);
    step(3'b000, 4'b0110, 1'b0);
    for (int c = 0; c < 8; c++) step(3'(c), 4'hC, 1'b1);
    // walk a single one through all positions in each direction
    step(3'b000, 4'h0, 1'b0);
    step(3'b110, 4'h0, 1'b1);
    for (int i = 0; i < W; i++) step(3'b110, 4'h0, 1'b0);
    step(3'b100, 4'h0, 1'b1);
    for (int i = 0; i < W; i++) step(3'b100, 4'h0, 1'b0);
    for (int i = 0; i < 300; i++)
      step(3'($urandom_range(0, 7)), 4'($urandom), 1'($urandom));

    // asynchronous reset mid-cycle during a shift-up
    step(3'b000, 4'b1001, 1'b0);
    @(negedge clk);
    dest_i = 3'b110; lo_en = 1'b1; lo_val = 1'b1; hi_en = 1'b0;
    #2 rst_ni = 1'b0;
    #1 chk("R1 async clear", q_o, '0);
    exp_q = '0;
    chk("R5 hi pin after clear", {{(W-1){1'b0}}, shift_hi}, '0);
    @(posedge clk);
    #1 chk("R1 override shift", q_o, '0);
    @(negedge clk);
    dest_i = 3'b000; f_i = 4'hF; lo_en = 1'b0;
    @(posedge clk);
    #1 chk("R1 override load", q_o, '0);
    @(negedge clk) rst_ni = 1'b1;
    step(3'b000, 4'b0101, 1'b0);
    step(3'b111, 4'hA, 1'b0);
    finish_run();
  end
endmodule